// File: doc/BRIEF.md
# Dual-Rail to LEDR Output Converter

This block sits at the output edge of a four-phase dual-rail function block and turns each result bit into a level-encoded two-wire (LEDR) bit for the next node. Each bit has its own cell. A true rail or a false rail going high moves the bit's data wire at once, without waiting for the other bits. The data wire keeps its value while the function block returns to zero. The parity wire is written with the data wire and follows from the new data value and the phase being produced. Because the phase alternates from one data item to the next, each item changes exactly one of the two wires of every bit.

The phase used for parity passes through a hold element. While the function block reports evaluation complete, the element holds the phase, so the next item's phase can arrive early without disturbing the parity of the current item. Once return-to-zero has finished, the element passes the incoming phase straight through. A per-bit XOR of the data and parity wires recovers each bit's phase. A completion tree combines these bits with C-element behaviour and raises or lowers a single done level. The model is synchronous: every wire update is taken on the clock.

Top module: `dr_ledr_outconv`

## Requirements
- R1: While reset is high, all data wires, all parity wires and the completion output are 0. This is the even-phase code of the value 0.
- R2: In the cycle after a bit's true rail is high and its false rail is low, that bit's data wire is 1. In the cycle after its false rail is high and its true rail is low, the data wire is 0. After a full item, the data wires equal the dual-rail value.
- R3: While both rails of a bit are low (spacer), that bit's data and parity wires keep their values.
- R4: Each bit converts in the cycle after its own rails evaluate. Bits whose rails are still spacer keep their previous values.
- R5: When a bit converts, its parity wire equals the data value XOR the phase in use (0 = even, 1 = odd). In even phase parity equals data. In odd phase it is the inverse of data.
- R6: While the four-phase completion input is high, the phase in use stays fixed and a change on the incoming phase does not alter parity. While the completion input is low, the incoming phase is used directly.
- R7: In the cycle after data XOR parity is 1 on every bit, the completion output is 1. In the cycle after it is 0 on every bit, the output is 0. When the bits are mixed, the output holds.
- R8: Within one data item, each bit changes exactly one of its two wires, and no bit changes both wires in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_t | input | W | True rails of the dual-rail result |
| rail_f | input | W | False rails of the dual-rail result |
| fn_done | input | 1 | Four-phase completion of the function block (high = evaluated, low = reset finished) |
| ph_next | input | 1 | Phase of the item being produced (0 even, 1 odd) |
| ledr_d | output | W | LEDR data wires |
| ledr_p | output | W | LEDR parity wires |
| ledr_done | output | 1 | Output completion level (equals the phase of the last complete word) |

## Verification
The assertions check the following on every cycle:
- the set and clear action of each rail pair;
- that a spacer holds both wires;
- the parity relation against the phase actually in use;
- that the held phase stays frozen across cycles with completion high;
- the completion tree's all-agree behaviour;
- that no bit ever moves both wires at once.

Some behaviours can only be shown by the bench's scenarios:
- bit-by-bit conversion in scrambled orders;
- completion holding while a word is half converted;
- an early phase change during evaluation having no visible effect;
- exactly one wire change per bit across a whole item, with the decoded word matching the dual-rail word.

// File: rtl/ledr_oc_pkg.sv
package ledr_oc_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } ledr_phase_e;

    // {true, false} rail code of one dual-rail bit
    typedef enum logic [1:0] {
        DR_SPACER = 2'b00,
        DR_ZERO   = 2'b01,
        DR_ONE    = 2'b10,
        DR_BAD    = 2'b11
    } dr_code_e;

    typedef struct packed {
        logic t;
        logic f;
    } dr_pair_t;

    typedef struct packed {
        logic d;
        logic p;
    } ledr_wire_t;

    function automatic dr_code_e dr_classify(dr_pair_t pr);
        return dr_code_e'({pr.t, pr.f});
    endfunction

    function automatic logic ledr_parity(logic d, ledr_phase_e ph);
        return d ^ logic'(ph);
    endfunction

endpackage

// File: rtl/ledr_phase_hold.sv
module ledr_phase_hold
    import ledr_oc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fn_done,
    input  logic        ph_next,
    output ledr_phase_e ph_use
);
    ledr_phase_e held_q;

    // open while return-to-zero has finished, closed while evaluated
    assign ph_use = fn_done ? held_q : ledr_phase_e'(ph_next);

    always_ff @(posedge clk) begin
        if (rst) held_q <= PH_EVEN;
        else     held_q <= ph_use;
    end
endmodule

// File: rtl/ledr_bit_cell.sv
module ledr_bit_cell
    import ledr_oc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  dr_pair_t    rails,
    input  ledr_phase_e ph_use,
    output ledr_wire_t  wire_q
);
    ledr_wire_t wire_n;

    always_comb begin
        wire_n = wire_q;
        case (dr_classify(rails))
            DR_ONE: begin
                wire_n.d = 1'b1;
                wire_n.p = ledr_parity(1'b1, ph_use);
            end
            DR_ZERO: begin
                wire_n.d = 1'b0;
                wire_n.p = ledr_parity(1'b0, ph_use);
            end
            default: wire_n = wire_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) wire_q <= '0;
        else     wire_q <= wire_n;
    end
endmodule

// File: rtl/ledr_cd_tree.sv
module ledr_cd_tree #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bit_phase,
    output logic         done
);
    localparam int LEVELS = (W > 1) ? $clog2(W) : 1;
    localparam int LEAVES = 1 << LEVELS;

    logic [2*LEAVES-1:1] one_n;
    logic [2*LEAVES-1:1] zero_n;

    genvar j;
    generate
        for (j = 0; j < LEAVES; j++) begin : g_leaf
            if (j < W) begin : g_real
                assign one_n[LEAVES+j]  = bit_phase[j];
                assign zero_n[LEAVES+j] = ~bit_phase[j];
            end else begin : g_pad
                assign one_n[LEAVES+j]  = bit_phase[0];
                assign zero_n[LEAVES+j] = ~bit_phase[0];
            end
        end
        for (j = 1; j < LEAVES; j++) begin : g_node
            assign one_n[j]  = one_n[2*j]  & one_n[2*j+1];
            assign zero_n[j] = zero_n[2*j] & zero_n[2*j+1];
        end
    endgenerate

    // C-element state at the root: move only when all inputs agree
    always_ff @(posedge clk) begin
        if (rst)            done <= 1'b0;
        else if (one_n[1])  done <= 1'b1;
        else if (zero_n[1]) done <= 1'b0;
    end
endmodule

// File: rtl/dr_ledr_outconv.sv
module dr_ledr_outconv
    import ledr_oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    input  logic         fn_done,
    input  logic         ph_next,
    output logic [W-1:0] ledr_d,
    output logic [W-1:0] ledr_p,
    output logic         ledr_done
);
    ledr_phase_e    ph_use;
    ledr_wire_t     wires [W];
    logic [W-1:0]   bit_phase;

    ledr_phase_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .fn_done (fn_done),
        .ph_next (ph_next),
        .ph_use  (ph_use)
    );

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            dr_pair_t pr;
            assign pr = '{t: rail_t[i], f: rail_f[i]};
            ledr_bit_cell u_cell (
                .clk    (clk),
                .rst    (rst),
                .rails  (pr),
                .ph_use (ph_use),
                .wire_q (wires[i])
            );
            assign ledr_d[i]    = wires[i].d;
            assign ledr_p[i]    = wires[i].p;
            assign bit_phase[i] = wires[i].d ^ wires[i].p;
        end
    endgenerate

    ledr_cd_tree #(.W(W)) u_cd (
        .clk       (clk),
        .rst       (rst),
        .bit_phase (bit_phase),
        .done      (ledr_done)
    );
endmodule

// File: rtl/ledr_oc_checker.sv
module ledr_oc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] rail_t,
    input logic [W-1:0] rail_f,
    input logic         fn_done,
    input logic         ph_use,
    input logic [W-1:0] ledr_d,
    input logic [W-1:0] ledr_p,
    input logic         ledr_done
);
    logic [W-1:0] set_v, clr_v, ev_v, xph;
    assign set_v = rail_t & ~rail_f;
    assign clr_v = rail_f & ~rail_t;
    assign ev_v  = rail_t ^ rail_f;
    assign xph   = ledr_d ^ ledr_p;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (ledr_d == '0 && ledr_p == '0 && !ledr_done));

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((ledr_d & $past(set_v)) == $past(set_v)));

    assert_clr_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_v != '0) |=> ((ledr_d & $past(clr_v)) == '0));

    assert_spacer_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((rail_t | rail_f) == '0) |=> ($stable(ledr_d) && $stable(ledr_p)));

    assert_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_v != '0) |=> ((xph & $past(ev_v)) == ($past(ev_v) & {W{$past(ph_use)}})));

    assert_phase_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (fn_done && $past(fn_done)) |-> (ph_use == $past(ph_use)));

    assert_done_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (xph == '1) |=> ledr_done);

    assert_done_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (xph == '0) |=> !ledr_done);

    assert_one_wire_R8: assert property (@(posedge clk) disable iff (rst)
        $countones((ledr_d ^ $past(ledr_d)) & (ledr_p ^ $past(ledr_p))) == 0);
endmodule

bind dr_ledr_outconv ledr_oc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rail_t    (rail_t),
    .rail_f    (rail_f),
    .fn_done   (fn_done),
    .ph_use    (ph_use),
    .ledr_d    (ledr_d),
    .ledr_p    (ledr_p),
    .ledr_done (ledr_done)
);

// File: tb/tb_dr_ledr_outconv.sv
module tb_dr_ledr_outconv;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] rail_t = '0;
    logic [W-1:0] rail_f = '0;
    logic         fn_done = 1'b0;
    logic         ph_next = 1'b0;
    logic [W-1:0] ledr_d, ledr_p;
    logic         ledr_done;

    dr_ledr_outconv #(.W(W)) dut (
        .clk(clk), .rst(rst), .rail_t(rail_t), .rail_f(rail_f),
        .fn_done(fn_done), .ph_next(ph_next),
        .ledr_d(ledr_d), .ledr_p(ledr_p), .ledr_done(ledr_done)
    );

    // behavioural reference, updated on each rising edge
    logic [W-1:0] m_d = '0, m_p = '0;
    logic         m_held = 1'b0, m_done = 1'b0;
    logic         lat_v;
    logic [W-1:0] x_v;

    always @(posedge clk) begin
        if (rst) begin
            m_d <= '0; m_p <= '0; m_held <= 1'b0; m_done <= 1'b0;
        end else begin
            lat_v = fn_done ? m_held : ph_next;
            m_held <= lat_v;
            x_v = m_d ^ m_p;
            if (x_v == '1)      m_done <= 1'b1;
            else if (x_v == '0) m_done <= 1'b0;
            for (int b = 0; b < W; b++) begin
                if (rail_t[b] && !rail_f[b]) begin
                    m_d[b] <= 1'b1; m_p[b] <= ~lat_v;
                end else if (rail_f[b] && !rail_t[b]) begin
                    m_d[b] <= 1'b0; m_p[b] <= lat_v;
                end
            end
        end
    end

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(ledr_d == m_d, "R2 data wires vs model", ledr_d, m_d);
            chk(ledr_p == m_p, "R5 parity wires vs model", ledr_p, m_p);
            chk(ledr_done == m_done, "R7 completion vs model", W'(ledr_done), W'(m_done));
        end
    end

    task automatic send_item(int k, logic [W-1:0] val, logic ph);
        logic [W-1:0] d0, p0, prev, msk, p_eval;
        ph_next = ph;
        d0 = ledr_d;
        p0 = ledr_p;
        for (int i = 0; i < W; i++) begin
            int b;
            b = (i * 3 + k) % W;
            msk = '0;
            msk[b] = 1'b1;
            prev = ledr_d;
            rail_t[b] = val[b];
            rail_f[b] = ~val[b];
            @(negedge clk);
            chk(ledr_d[b] == val[b], "R4 bit converts alone", W'(ledr_d[b]), W'(val[b]));
            chk((ledr_d & ~msk) == (prev & ~msk), "R4 other bits unchanged",
                ledr_d & ~msk, prev & ~msk);
            if (i == W/2)
                chk(ledr_done == ~ph, "R7 hold on mixed word", W'(ledr_done), W'(~ph));
        end
        fn_done = 1'b1;
        @(negedge clk);
        chk(ledr_done == ph, "R7 done follows word phase", W'(ledr_done), W'(ph));
        chk(ledr_p == (ledr_d ^ {W{ph}}), "R5 parity relation", ledr_p, ledr_d ^ {W{ph}});
        p_eval = ledr_p;
        ph_next = ~ph;
        repeat (2) @(negedge clk);
        chk(ledr_p == p_eval, "R6 early phase blocked", ledr_p, p_eval);
        rail_t = '0;
        rail_f = '0;
        repeat (2) @(negedge clk);
        chk(ledr_p == p_eval, "R3 spacer holds parity", ledr_p, p_eval);
        chk(ledr_d == val, "R3 spacer holds data", ledr_d, val);
        fn_done = 1'b0;
        @(negedge clk);
        chk((((d0 ^ ledr_d) ^ (p0 ^ ledr_p)) == '1) && (((d0 ^ ledr_d) & (p0 ^ ledr_p)) == '0),
            "R8 one wire per bit per item", (d0 ^ ledr_d) | ((p0 ^ ledr_p) << 1), '1);
        chk(ledr_d == val, "R2 decoded word", ledr_d, val);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ledr_d == '0 && ledr_p == '0 && !ledr_done, "R1 reset state",
            ledr_d | ledr_p | W'(ledr_done), '0);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            logic [W-1:0] v;
            v = (k == 0) ? '1 : (k == 1) ? '0 : W'(k * 37 + 5);
            send_item(k, v, logic'((k + 1) % 2));
        end
        // phase passes straight through once reset is finished (R6)
        ph_next = 1'b1;
        rail_t = 8'h0F;
        rail_f = 8'hF0;
        @(negedge clk);
        chk(ledr_p == (ledr_d ^ {W{1'b1}}), "R6 open latch uses new phase",
            ledr_p, ledr_d ^ {W{1'b1}});
        rail_t = '0;
        rail_f = '0;
        repeat (2) @(negedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            finished = 1'b1;
            summary();
            $finish;
        end
    end
endmodule